// File: doc/BRIEF.md
# SMBus Host Register and Status Unit

This block is the register file that software uses to run an SMBus host controller. Software reaches it through a byte-wide port with sixteen byte addresses. Through that port it loads a command byte, a target address and two data bytes. It then writes a start request into the control register and polls or takes an interrupt on the status register. A separate transaction sequencer drives the bus itself. This unit hands that sequencer a start pulse, a kill pulse, a three-bit protocol code and the loaded bytes. In return it takes done, error and byte-done events, and the bytes read from the bus.

The status register has three features that software relies on. Its flags clear only when software writes a one to them. It carries a hardware semaphore: the first status read that sees the semaphore clear also claims it. It paces block transfers one byte at a time. The sequencer raises byte-done and then waits. Software moves one byte through the block data register and writes a one to byte-done, and that releases the sequencer for the next byte. A configuration input picks I2C-style block handling, and the unit samples it when a start is accepted.

Top module: `smb_host_regs`

## Requirements
- R1: After synchronous reset every register reads 0x00. The outputs seq_start, seq_kill, blk_push, blk_wait and irq are 0, and seq_proto is 0.
- R2: The semaphore is status bit 6. A status read (offset 0) returns its current value. If that value was 0, the bit becomes 1 at the clock edge of the read, so later reads return 1 until software writes status with bit 6 set.
- R3: Status flags are done (bit 1), device error (bit 2), kill-failed (bit 4), semaphore (bit 6) and byte-done (bit 7). Writing 1 to a flag clears it, and writing 0 leaves it unchanged. Busy (bit 0) is not changed by software writes. Bits 3 and 5 read 0. So writing 0xBF keeps only the semaphore, and writing 0xFF clears every flag.
- R4: When a sequencer event and a software write of 1 hit the same flag in the same cycle, the flag ends up set.
- R5: A control write (offset 2) with bit 6 = 1 starts a transaction when busy is 0, the stored kill bit is 0 and the written bit 1 is 0. seq_start then pulses for exactly the next cycle, and busy (status bit 0) is 1 from that cycle on. Bit 6 always reads back 0.
- R6: A start request made while busy is 1, or while the stored kill bit is 1, produces no seq_start pulse.
- R7: seq_done clears busy and sets done (bit 1). seq_error clears busy and sets device error (bit 2).
- R8: A control write that changes bit 1 from 0 to 1 pulses seq_kill for the next cycle and clears busy. It sets kill-failed (bit 4) only if busy was 1. The kill bit stays 1, and no further pulse comes, until software writes bit 1 as 0.
- R9: Control bits 4:2 are the protocol code driven on seq_proto, and bit 0 is interrupt enable. Control reads return {3'b000, code, kill, enable}.
- R10: Offsets 3 to 11 are byte registers that read back what was written. Offset 3 is the command, 4 the target address, 5 data 0, 6 data 1, 7 block data, 8 packet check, 9 receive address, and 10 and 11 the slave data low and high bytes. Offsets 3 to 7 drive seq_cmd, seq_taddr, seq_data0, seq_data1 and blk_byte. Offsets 1 and 12 to 15 read 0 and ignore writes.
- R11: seq_rx_we loads seq_rx_byte into data 0 when seq_rx_sel = 0, into data 1 when it is 1, and into block data when it is 2. A select value of 3 changes nothing.
- R12: seq_byte_done sets byte-done (bit 7), and blk_wait mirrors that flag. A write to block data while byte-done is 1 pulses blk_push for the next cycle, with the new byte on blk_byte. A write to block data while byte-done is 0 gives no pulse.
- R13: seq_i2c holds the value of cfg_i2c_mode sampled at the last accepted start. Later changes to the input do not affect it.
- R14: irq equals interrupt enable AND (done OR kill-failed OR byte-done). Device error alone raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (claims the semaphore on a status read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| cfg_i2c_mode | input | 1 | Selects I2C-style block handling |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_kill | output | 1 | One-cycle abort pulse to the sequencer |
| seq_proto | output | 3 | Protocol code |
| seq_i2c | output | 1 | I2C mode latched at start |
| seq_cmd | output | 8 | Command byte |
| seq_taddr | output | 8 | Target address byte |
| seq_data0 | output | 8 | Data 0 byte |
| seq_data1 | output | 8 | Data 1 byte |
| seq_done | input | 1 | Transaction completed event |
| seq_error | input | 1 | Transaction error event |
| seq_byte_done | input | 1 | Block byte finished event |
| seq_rx_we | input | 1 | Received-byte load strobe |
| seq_rx_sel | input | 2 | Load target: 0 data 0, 1 data 1, 2 block data |
| seq_rx_byte | input | 8 | Received byte |
| blk_byte | output | 8 | Block data register |
| blk_push | output | 1 | One-cycle pulse: new block byte handed over |
| blk_wait | output | 1 | Sequencer must hold (byte-done flag) |
| irq | output | 1 | Interrupt request |

## Verification
Reads are combinational, so a read reports the state left by the previous edge. The semaphore claim made by that read shows only on the following read. Register writes and sequencer events take effect at the edge on which they are sampled. The seq_start, seq_kill and blk_push pulses and the new busy value are therefore high for exactly the one cycle after the write. The bench drives every stimulus on the falling edge and releases it on the next falling edge. It samples pulses at that release point, and it samples again one cycle later to confirm each pulse has dropped. It tracks the semaphore in its own variable so that the expected value of every status read is known.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    parameter int AW = 4;
    parameter int DW = 8;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    // Offsets decoded by software and by the sequencer hookup
    localparam addr_t OFS_STAT  = 4'h0;
    localparam addr_t OFS_CTRL  = 4'h2;
    localparam addr_t OFS_D0    = 4'h5;
    localparam addr_t OFS_D1    = 4'h6;
    localparam addr_t OFS_BLK   = 4'h7;

    // Contiguous byte bank: command .. slave data high
    localparam int DATA_BASE = 3;
    localparam int DATA_CNT  = 9;
    localparam int SLOT_CMD  = 0;
    localparam int SLOT_TADR = 1;
    localparam int SLOT_D0   = 2;
    localparam int SLOT_D1   = 3;
    localparam int SLOT_BLK  = 4;

    typedef enum logic [1:0] {
        RX_D0   = 2'd0,
        RX_D1   = 2'd1,
        RX_BLK  = 2'd2,
        RX_NONE = 2'd3
    } rx_sel_e;

    typedef struct packed {
        logic bdone;
        logic inuse;
        logic fail;
        logic derr;
        logic done;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic bdone;
        logic inuse;
        logic fail;
        logic derr;
        logic done;
    } clr_t;

    // Byte image of status: 7 bdone, 6 inuse, 4 fail, 2 derr, 1 done, 0 busy
    function automatic byte_t stat_pack(stat_t s);
        return {s.bdone, s.inuse, 1'b0, s.fail, 1'b0, s.derr, s.done, s.busy};
    endfunction

    function automatic clr_t clr_unpack(byte_t w);
        return '{bdone: w[7], inuse: w[6], fail: w[4], derr: w[2], done: w[1]};
    endfunction

    // Set event has priority over a write-one clear
    function automatic logic flag_next(logic cur, logic set_ev, logic clr);
        return set_ev | (cur & ~clr);
    endfunction

    function automatic rx_sel_e rx_slot_of(int ofs);
        if (ofs == int'(OFS_D0))  return RX_D0;
        if (ofs == int'(OFS_D1))  return RX_D1;
        if (ofs == int'(OFS_BLK)) return RX_BLK;
        return RX_NONE;
    endfunction

endpackage

// File: rtl/smb_status_unit.sv
module smb_status_unit
    import smb_host_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stat_wr,
    input  clr_t  clr,
    input  logic  stat_rd,
    input  logic  start_ok,
    input  logic  kill_rise,
    input  logic  ev_done,
    input  logic  ev_err,
    input  logic  ev_bdone,
    output stat_t st
);

    logic  claim;
    clr_t  cm;

    assign claim = stat_rd & ~stat_wr;
    assign cm    = stat_wr ? clr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (kill_rise)
                st.busy <= 1'b0;
            else if (start_ok)
                st.busy <= 1'b1;
            else if (ev_done || ev_err)
                st.busy <= 1'b0;

            st.done  <= flag_next(st.done,  ev_done,              cm.done);
            st.derr  <= flag_next(st.derr,  ev_err,               cm.derr);
            st.fail  <= flag_next(st.fail,  kill_rise & st.busy,  cm.fail);
            st.bdone <= flag_next(st.bdone, ev_bdone,             cm.bdone);
            st.inuse <= flag_next(st.inuse, claim,                cm.inuse);
        end
    end

endmodule

// File: rtl/smb_ctrl_unit.sv
module smb_ctrl_unit
    import smb_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic       w_start,
    input  logic [2:0] w_proto,
    input  logic       w_kill,
    input  logic       w_ien,
    input  logic       busy,
    input  logic       cfg_i2c,
    output logic       start_ok,
    output logic       kill_rise,
    output logic       seq_start,
    output logic       seq_kill,
    output logic [2:0] proto,
    output logic       kill_lvl,
    output logic       ien,
    output logic       seq_i2c,
    output byte_t      ctrl_rd
);

    assign start_ok  = ctrl_wr & w_start & ~w_kill & ~busy & ~kill_lvl;
    assign kill_rise = ctrl_wr & w_kill & ~kill_lvl;
    assign ctrl_rd   = {3'b000, proto, kill_lvl, ien};

    always_ff @(posedge clk) begin
        if (rst) begin
            proto     <= '0;
            kill_lvl  <= 1'b0;
            ien       <= 1'b0;
            seq_start <= 1'b0;
            seq_kill  <= 1'b0;
            seq_i2c   <= 1'b0;
        end else begin
            seq_start <= start_ok;
            seq_kill  <= kill_rise;
            if (ctrl_wr) begin
                proto    <= w_proto;
                kill_lvl <= w_kill;
                ien      <= w_ien;
            end
            if (start_ok)
                seq_i2c <= cfg_i2c;
        end
    end

endmodule

// File: rtl/smb_data_bank.sv
module smb_data_bank
    import smb_host_pkg::*;
#(
    parameter int BASE = DATA_BASE,
    parameter int CNT  = DATA_CNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  addr_t               addr,
    input  byte_t               wdata,
    input  logic                rx_we,
    input  rx_sel_e             rx_sel,
    input  byte_t               rx_byte,
    output logic [CNT-1:0][DW-1:0] q
);

    for (genvar i = 0; i < CNT; i++) begin : g_slot
        localparam int      OFS   = BASE + i;
        localparam rx_sel_e MY_RX = rx_slot_of(OFS);
        logic  rx_hit;
        logic  sw_hit;
        byte_t slot_q;

        assign rx_hit = rx_we && (MY_RX != RX_NONE) && (rx_sel == MY_RX);
        assign sw_hit = wr && (addr == AW'(OFS));
        assign q[i]   = slot_q;

        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (rx_hit)
                slot_q <= rx_byte;
            else if (sw_hit)
                slot_q <= wdata;
        end
    end

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cfg_i2c_mode,
    output logic       seq_start,
    output logic       seq_kill,
    output logic [2:0] seq_proto,
    output logic       seq_i2c,
    output logic [7:0] seq_cmd,
    output logic [7:0] seq_taddr,
    output logic [7:0] seq_data0,
    output logic [7:0] seq_data1,
    input  logic       seq_done,
    input  logic       seq_error,
    input  logic       seq_byte_done,
    input  logic       seq_rx_we,
    input  logic [1:0] seq_rx_sel,
    input  logic [7:0] seq_rx_byte,
    output logic [7:0] blk_byte,
    output logic       blk_push,
    output logic       blk_wait,
    output logic       irq
);

    stat_t st;
    logic  stat_wr, stat_rd, ctrl_wr;
    logic  start_ok, kill_rise, kill_lvl, ien;
    byte_t ctrl_rd;
    logic [DATA_CNT-1:0][DW-1:0] bank_q;
    logic  push_q;

    assign stat_wr = reg_wr && (reg_addr == OFS_STAT);
    assign stat_rd = reg_rd && (reg_addr == OFS_STAT);
    assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);

    smb_status_unit u_status (
        .clk       (clk),
        .rst       (rst),
        .stat_wr   (stat_wr),
        .clr       (clr_unpack(reg_wdata)),
        .stat_rd   (stat_rd),
        .start_ok  (start_ok),
        .kill_rise (kill_rise),
        .ev_done   (seq_done),
        .ev_err    (seq_error),
        .ev_bdone  (seq_byte_done),
        .st        (st)
    );

    smb_ctrl_unit u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .w_start   (reg_wdata[6]),
        .w_proto   (reg_wdata[4:2]),
        .w_kill    (reg_wdata[1]),
        .w_ien     (reg_wdata[0]),
        .busy      (st.busy),
        .cfg_i2c   (cfg_i2c_mode),
        .start_ok  (start_ok),
        .kill_rise (kill_rise),
        .seq_start (seq_start),
        .seq_kill  (seq_kill),
        .proto     (seq_proto),
        .kill_lvl  (kill_lvl),
        .ien       (ien),
        .seq_i2c   (seq_i2c),
        .ctrl_rd   (ctrl_rd)
    );

    smb_data_bank #(
        .BASE (DATA_BASE),
        .CNT  (DATA_CNT)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rx_we   (seq_rx_we),
        .rx_sel  (rx_sel_e'(seq_rx_sel)),
        .rx_byte (seq_rx_byte),
        .q       (bank_q)
    );

    // Hand-over of a block byte only while the sequencer is parked
    always_ff @(posedge clk) begin
        if (rst)
            push_q <= 1'b0;
        else
            push_q <= reg_wr && (reg_addr == OFS_BLK) && st.bdone;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STAT)
            reg_rdata = stat_pack(st);
        else if (reg_addr == OFS_CTRL)
            reg_rdata = ctrl_rd;
        else
            for (int i = 0; i < DATA_CNT; i++)
                if (reg_addr == AW'(DATA_BASE + i))
                    reg_rdata = bank_q[i];
    end

    assign seq_cmd   = bank_q[SLOT_CMD];
    assign seq_taddr = bank_q[SLOT_TADR];
    assign seq_data0 = bank_q[SLOT_D0];
    assign seq_data1 = bank_q[SLOT_D1];
    assign blk_byte  = bank_q[SLOT_BLK];
    assign blk_push  = push_q;
    assign blk_wait  = st.bdone;
    assign irq       = ien & (st.done | st.fail | st.bdone);

endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk
    import smb_host_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] reg_addr,
    input logic       start_bit,
    input logic       seq_start,
    input logic       seq_kill,
    input logic       irq,
    input logic       blk_push,
    input logic       busy,
    input logic       inuse,
    input logic       bdone,
    input logic       ien,
    input logic       kill_lvl
);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> busy);                                               // R5
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> !seq_start);                                         // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTRL && start_bit && (busy || kill_lvl))
        |=> !seq_start);                                                   // R6
    AST_KILL_IDLE: assert property (@(posedge clk) disable iff (rst)
        seq_kill |-> !busy);                                               // R8
    AST_INUSE_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == OFS_STAT) |=> inuse);            // R2
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        !ien |-> !irq);                                                    // R14
    AST_PUSH_PARKED: assert property (@(posedge clk) disable iff (rst)
        blk_push |-> $past(bdone));                                        // R12

endmodule

bind smb_host_regs smb_host_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .start_bit (reg_wdata[6]),
    .seq_start (seq_start),
    .seq_kill  (seq_kill),
    .irq       (irq),
    .blk_push  (blk_push),
    .busy      (st.busy),
    .inuse     (st.inuse),
    .bdone     (st.bdone),
    .ien       (ien),
    .kill_lvl  (kill_lvl)
);

// File: tb/smb_host_regs_bench.sv
`timescale 1ns/1ps
module smb_host_regs_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cfg_i2c_mode = 1'b0;
    logic       seq_start, seq_kill, seq_i2c;
    logic [2:0] seq_proto;
    logic [7:0] seq_cmd, seq_taddr, seq_data0, seq_data1, blk_byte;
    logic       seq_done = 1'b0, seq_error = 1'b0, seq_byte_done = 1'b0;
    logic       seq_rx_we = 1'b0;
    logic [1:0] seq_rx_sel = '0;
    logic [7:0] seq_rx_byte = '0;
    logic       blk_push, blk_wait, irq;

    int nchk = 0;
    int nfail = 0;
    logic m_inuse = 1'b0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    smb_host_regs u_smb_host_regs (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 4'h0 && d[6]) m_inuse = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        if (a == 4'h0) m_inuse = 1'b1;
    endtask

    // status read: expected value given without the semaphore bit
    task automatic chk_stat(string tag, logic [7:0] exp_wo);
        logic [7:0] v;
        logic [7:0] e;
        e = exp_wo | (m_inuse ? 8'h40 : 8'h00);
        rd(4'h0, v);
        chk(tag, v, e);
    endtask

    task automatic ev(logic d, logic e, logic b);
        @(negedge clk);
        seq_done = d; seq_error = e; seq_byte_done = b;
        @(negedge clk);
        seq_done = 0; seq_error = 0; seq_byte_done = 0;
    endtask

    task automatic rx(logic [1:0] s, logic [7:0] b);
        @(negedge clk);
        seq_rx_we = 1'b1; seq_rx_sel = s; seq_rx_byte = b;
        @(negedge clk);
        seq_rx_we = 1'b0;
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) ^ 8'h5C);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 outs", {seq_start, seq_kill, blk_push, blk_wait, irq, seq_proto}, 0);
        chk_stat("R1 status", 8'h00);
        for (int a = 1; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 reg", v, 0);
        end

        // R2: semaphore claim and release
        chk_stat("R2 claimed", 8'h00);
        chk_stat("R2 sticky", 8'h00);
        wr(4'h0, 8'h40);
        chk_stat("R2 released", 8'h00);
        rd(4'h0, v);
        chk("R2 reclaimed", v, 8'h40);

        // R10: address sweep
        for (int a = 1; a < 16; a++)
            if (a != 2) wr(4'(a), pat(a));
        for (int a = 1; a < 16; a++) begin
            if (a == 2) continue;
            rd(4'(a), v);
            chk("R10 readback", v, (a >= 3 && a <= 11) ? pat(a) : 8'h00);
        end
        chk("R10 seq_cmd", seq_cmd, pat(3));
        chk("R10 seq_taddr", seq_taddr, pat(4));
        chk("R10 seq_data0", seq_data0, pat(5));
        chk("R10 seq_data1", seq_data1, pat(6));
        chk("R10 blk_byte", blk_byte, pat(7));
        chk("R12 no push while idle", blk_push, 0);

        // R9: protocol code sweep
        for (int p = 0; p < 8; p++) begin
            wr(4'h2, 8'((p << 2) | 1));
            chk("R9 seq_proto", seq_proto, p);
            rd(4'h2, v);
            chk("R9 ctrl read", v, (p << 2) | 1);
        end
        wr(4'h2, 8'h00);

        // R5, R13: start
        cfg_i2c_mode = 1'b1;
        wr(4'h2, 8'h48);
        chk("R5 start pulse", seq_start, 1);
        chk("R13 i2c latched", seq_i2c, 1);
        cfg_i2c_mode = 1'b0;
        @(negedge clk);
        chk("R5 pulse one cycle", seq_start, 0);
        chk_stat("R5 busy", 8'h01);
        rd(4'h2, v);
        chk("R5 start reads 0", v, 8'h08);
        chk("R13 i2c held", seq_i2c, 1);

        // R6: start while busy
        wr(4'h2, 8'h44);
        chk("R6 ignored busy", seq_start, 0);
        chk_stat("R6 still busy", 8'h01);

        // R7, R14
        ev(1, 0, 0);
        chk_stat("R7 done", 8'h02);
        chk("R14 irq masked", irq, 0);
        wr(4'h2, 8'h01);
        chk("R14 irq done", irq, 1);
        wr(4'h0, 8'h02);
        chk("R14 irq cleared", irq, 0);
        chk_stat("R3 done cleared", 8'h00);
        wr(4'h2, 8'h41);
        chk("R13 i2c resampled", seq_i2c, 0);
        ev(0, 1, 0);
        chk_stat("R7 error", 8'h04);
        chk("R14 derr no irq", irq, 0);
        wr(4'h0, 8'h04);

        // R8: kill while busy
        wr(4'h2, 8'h41);
        wr(4'h2, 8'h03);
        chk("R8 kill pulse", seq_kill, 1);
        @(negedge clk);
        chk("R8 kill one cycle", seq_kill, 0);
        chk_stat("R8 failed", 8'h10);
        chk("R14 irq failed", irq, 1);
        rd(4'h2, v);
        chk("R8 kill held", v, 8'h03);
        wr(4'h2, 8'h03);
        chk("R8 no repeat pulse", seq_kill, 0);
        wr(4'h2, 8'h41);
        chk("R6 ignored kill held", seq_start, 0);
        wr(4'h2, 8'h41);
        chk("R5 start after release", seq_start, 1);
        ev(1, 0, 0);
        wr(4'h0, 8'hFF);
        m_inuse = 1'b0;
        wr(4'h2, 8'h02);
        chk("R8 idle kill pulse", seq_kill, 1);
        chk_stat("R8 idle no fail", 8'h00);
        wr(4'h2, 8'h00);

        // R3: clear-mask sweep over all write values
        for (int w = 0; w < 256; w++) begin
            wr(4'h2, 8'h41);
            wr(4'h2, 8'h03);
            wr(4'h2, 8'h00);
            ev(0, 1, 0);
            ev(1, 0, 1);
            rd(4'h0, v);
            wr(4'h0, 8'(w));
            if (w[6]) m_inuse = 1'b0;
            rd(4'h0, v);
            chk("R3 w1c sweep", v, 8'hD6 & ~8'(w));
        end
        wr(4'h0, 8'hFF);
        m_inuse = 1'b0;
        wr(4'h2, 8'h40);
        wr(4'h0, 8'hFF);
        chk_stat("R3 busy not writable", 8'h01);
        ev(1, 0, 0);
        wr(4'h0, 8'hBF);
        chk_stat("R3 0xBF keeps inuse", 8'h00);
        wr(4'h0, 8'hFF);
        m_inuse = 1'b0;
        chk_stat("R3 0xFF clears inuse", 8'h00);

        // R4: set beats clear
        @(negedge clk);
        reg_addr = 4'h0; reg_wdata = 8'h02; reg_wr = 1'b1; seq_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; seq_done = 1'b0;
        chk_stat("R4 set wins", 8'h02);
        wr(4'h0, 8'h02);

        // R11: sequencer loads
        rx(2'd0, 8'hA5);
        rx(2'd1, 8'h5A);
        rx(2'd2, 8'hC3);
        rx(2'd3, 8'h11);
        rd(4'h5, v); chk("R11 data0", v, 8'hA5);
        rd(4'h6, v); chk("R11 data1", v, 8'h5A);
        rd(4'h7, v); chk("R11 block", v, 8'hC3);
        rd(4'h3, v); chk("R11 sel3 ignored", v, pat(3));

        // R12: block handshake
        ev(0, 0, 1);
        chk("R12 wait set", blk_wait, 1);
        wr(4'h7, 8'h77);
        chk("R12 push", blk_push, 1);
        chk("R12 push byte", blk_byte, 8'h77);
        @(negedge clk);
        chk("R12 push one cycle", blk_push, 0);
        chk("R12 wait held", blk_wait, 1);
        wr(4'h0, 8'h80);
        chk("R12 wait released", blk_wait, 0);
        wr(4'h7, 8'h66);
        chk("R12 no push when clear", blk_push, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule